// File: doc/BRIEF.md
# PWM Fault Guard

The fault guard sits between a PWM generator and the output pads. It watches a set of fault pins, each with its own polarity, and cleans them with a sampled glitch filter that can be bypassed. A short pulse can be stretched before filtering. Each detected fault is latched. Any PWM output (A, B or X) whose per-output fault map selects that fault is then replaced by a programmed safe level: driven low, driven high, or released to tristate.

Each fault has a clearing mode and a recovery timing. In automatic mode the outputs come back once the fault has gone away. Manual mode also waits for software to clear the fault's sticky flag, and manual-safety mode accepts that clear only after the fault has ended. In every mode the outputs return only on the half-cycle or full-cycle strobe selected for that fault, so they rejoin the PWM waveform at a cycle boundary. For faults that must act at once, an optional path per fault takes the unfiltered pin level straight to the output gating.

Top module: `fault_guard`

## Requirements
- R1: After reset, every output passes its PWM input with its enable high, all fault flags and interrupt requests are 0, and every map bit is 1.
- R2: A fault is active on pin level 1 when bit i of `cfg_fault_high_i` is 1, and on pin level 0 when that bit is 0.
- R3: Output A, B or X is overridden while fault i is in force and bit i of its map is 1. The map is written as one word with A in bits [NF-1:0], B in [2NF-1:NF] and X in [3NF-1:2NF].
- R4: For an overridden output, safe code 0 drives 0 with the enable high, code 1 drives 1 with the enable high, and codes 2 and 3 drop the enable and drive the data 0.
- R5: With filter period 0 the filter is bypassed, and a pin change reaches the outputs one clock edge later.
- R6: With period P > 0, the pin is sampled every P cycles, and the filtered level changes only after C+1 consecutive samples that differ from it (C = `cfg_filt_cnt_i`). A one-cycle glitch with P=2 and C=1 sets no flag.
- R7: With stretch enabled, an active level is held for one more cycle before filtering, so a one-cycle pulse passes a P=1, C=1 filter. Without stretch the same pulse is rejected.
- R8: When bit i of `cfg_comb_en_i` is set, the raw active level of pin i overrides its mapped outputs in the same cycle, before any clock edge.
- R9: A flag sets on the onset of a filtered fault. It stays set until a 1 is written to its bit of `flag_clr_i`. `irq_o` is the flag ANDed with `irq_en_i`.
- R10: In clearing mode 0 (automatic) the override is released at the recovery point after the filtered fault has ended, with no software action.
- R11: In clearing mode 1 (manual) a flag clear is accepted even while the fault is still active. Release then follows at the first recovery point after the fault ends.
- R12: In clearing modes 2 and 3 (manual with safety) a flag clear is ignored while the filtered fault is active. The outputs stay overridden until the flag has been cleared after the fault ends.
- R13: Recovery code 0 never releases, 1 releases on `half_cyc_i`, 2 on `full_cyc_i`, and 3 on either strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_pin_i | input | NF | Raw fault pins |
| half_cyc_i | input | 1 | PWM half-cycle strobe |
| full_cyc_i | input | 1 | PWM full-cycle strobe |
| pwm_a_i | input | 1 | PWM A from the generator |
| pwm_b_i | input | 1 | PWM B from the generator |
| pwm_x_i | input | 1 | PWM X from the generator |
| cfg_fault_high_i | input | NF | Per-fault active level (1 = high active) |
| cfg_filt_per_i | input | PER_W | Filter sample period, 0 = bypass |
| cfg_filt_cnt_i | input | CNT_W | Extra consecutive samples needed |
| cfg_stretch_i | input | 1 | Glitch stretch enable |
| cfg_comb_en_i | input | NF | Per-fault unfiltered override enable |
| cfg_clr_mode_i | input | 2*NF | Clearing mode, 2 bits per fault |
| cfg_rec_mode_i | input | 2*NF | Recovery timing, 2 bits per fault |
| cfg_safe_a_i | input | 2 | Safe code for output A |
| cfg_safe_b_i | input | 2 | Safe code for output B |
| cfg_safe_x_i | input | 2 | Safe code for output X |
| map_wr_i | input | 1 | Map write strobe |
| map_wdata_i | input | 3*NF | Map write data {X, B, A} |
| flag_clr_i | input | NF | Write-one-to-clear of fault flags |
| irq_en_i | input | NF | Interrupt enables |
| pwm_a_o | output | 1 | Gated output A |
| pwm_b_o | output | 1 | Gated output B |
| pwm_x_o | output | 1 | Gated output X |
| oe_a_o | output | 1 | Enable of A (0 = tristate) |
| oe_b_o | output | 1 | Enable of B (0 = tristate) |
| oe_x_o | output | 1 | Enable of X (0 = tristate) |
| fault_flag_o | output | NF | Sticky fault flags |
| irq_o | output | NF | Interrupt requests |

## Verification
The bench targets the difference between the two manual modes. A flag clear written during an active fault must stick in manual mode but be dropped in safety mode; a design that confused the two would either lock the outputs off for good or re-enable them while the fault was still present. Recovery timing is checked by pulsing the strobe that was not selected, and by using code 0. A design that released early would restore the PWM mid-cycle, and one that ignored code 0 would recover when it must not. Single-cycle glitches are fed to the filter with and without stretching: a wrong sample count would either trip on noise or, with stretch, miss the pulse it should keep. A table of safe codes and map bits, applied through the unfiltered path, catches a wrong tristate decode or a map bit applied to the wrong output.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;
  typedef enum logic [1:0] {
    CLR_AUTO   = 2'd0,
    CLR_MANUAL = 2'd1,
    CLR_SAFE   = 2'd2,
    CLR_SAFE_B = 2'd3
  } clr_mode_e;

  typedef enum logic [1:0] {
    REC_NONE = 2'd0,
    REC_HALF = 2'd1,
    REC_FULL = 2'd2,
    REC_BOTH = 2'd3
  } rec_mode_e;

  typedef enum logic [1:0] {
    SAFE_LOW  = 2'd0,
    SAFE_HIGH = 2'd1,
    SAFE_HIZ  = 2'd2,
    SAFE_HIZ2 = 2'd3
  } safe_e;

  localparam int NUM_OUTS = 3;
endpackage

// File: rtl/fg_filter.sv
module fg_filter #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             stretch_en_i,
  input  logic             bypass_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             filt_o
);
  logic             act_q;
  logic             stretched;
  logic [CNT_W-1:0] run_q;

  assign stretched = act_i | (stretch_en_i & act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      filt_o <= 1'b0;
      run_q  <= '0;
    end else begin
      act_q <= act_i;
      if (bypass_i) begin
        filt_o <= stretched;
        run_q  <= '0;
      end else if (tick_i) begin
        if (stretched == filt_o) begin
          run_q <= '0;
        end else if (run_q == cnt_i) begin
          filt_o <= stretched;
          run_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fg_latch.sv
module fg_latch
  import fault_guard_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       filt_i,
  input  logic [1:0] clr_mode_i,
  input  logic [1:0] rec_mode_i,
  input  logic       half_i,
  input  logic       full_i,
  input  logic       clr_i,
  output logic       hold_o,
  output logic       flag_o
);
  logic filt_q;
  logic onset;
  logic safety;
  logic clr_ok;
  logic point;
  logic cond;
  logic release_now;

  assign onset  = filt_i & ~filt_q;
  assign safety = clr_mode_i[1];
  assign clr_ok = clr_i & ~(safety & filt_i);

  always_comb begin
    case (rec_mode_e'(rec_mode_i))
      REC_HALF: point = half_i;
      REC_FULL: point = full_i;
      REC_BOTH: point = half_i | full_i;
      default:  point = 1'b0;
    endcase
  end

  // manual modes also need the flag gone
  assign cond = (clr_mode_e'(clr_mode_i) == CLR_AUTO) ? ~filt_i : (~filt_i & ~flag_o);
  assign release_now = hold_o & point & cond;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      flag_o <= 1'b0;
      hold_o <= 1'b0;
    end else begin
      filt_q <= filt_i;
      flag_o <= onset | (flag_o & ~clr_ok);
      hold_o <= filt_i | (hold_o & ~release_now);
    end
  end
endmodule

// File: rtl/fg_gate.sv
module fg_gate
  import fault_guard_pkg::*;
#(
  parameter int NF = 4
) (
  input  logic          pwm_i,
  input  logic [NF-1:0] fault_i,
  input  logic [NF-1:0] map_i,
  input  logic [1:0]    safe_i,
  output logic          pwm_o,
  output logic          oe_o
);
  logic dis;

  assign dis = |(fault_i & map_i);

  always_comb begin
    pwm_o = pwm_i;
    oe_o  = 1'b1;
    if (dis) begin
      case (safe_e'(safe_i))
        SAFE_LOW:  begin pwm_o = 1'b0; oe_o = 1'b1; end
        SAFE_HIGH: begin pwm_o = 1'b1; oe_o = 1'b1; end
        default:   begin pwm_o = 1'b0; oe_o = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import fault_guard_pkg::*;
#(
  parameter int NF    = 4,
  parameter int PER_W = 8,
  parameter int CNT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NF-1:0]     fault_pin_i,
  input  logic              half_cyc_i,
  input  logic              full_cyc_i,
  input  logic              pwm_a_i,
  input  logic              pwm_b_i,
  input  logic              pwm_x_i,
  input  logic [NF-1:0]     cfg_fault_high_i,
  input  logic [PER_W-1:0]  cfg_filt_per_i,
  input  logic [CNT_W-1:0]  cfg_filt_cnt_i,
  input  logic              cfg_stretch_i,
  input  logic [NF-1:0]     cfg_comb_en_i,
  input  logic [2*NF-1:0]   cfg_clr_mode_i,
  input  logic [2*NF-1:0]   cfg_rec_mode_i,
  input  logic [1:0]        cfg_safe_a_i,
  input  logic [1:0]        cfg_safe_b_i,
  input  logic [1:0]        cfg_safe_x_i,
  input  logic              map_wr_i,
  input  logic [3*NF-1:0]   map_wdata_i,
  input  logic [NF-1:0]     flag_clr_i,
  input  logic [NF-1:0]     irq_en_i,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic              pwm_x_o,
  output logic              oe_a_o,
  output logic              oe_b_o,
  output logic              oe_x_o,
  output logic [NF-1:0]     fault_flag_o,
  output logic [NF-1:0]     irq_o
);
  localparam int MAP_W = NUM_OUTS * NF;

  logic [NF-1:0]    act_raw;
  logic [NF-1:0]    filt_act;
  logic [NF-1:0]    hold_q;
  logic [NF-1:0]    fault_now;
  logic [PER_W-1:0] per_cnt_q;
  logic             bypass;
  logic             tick;
  logic [MAP_W-1:0] map_q;
  logic [NF-1:0]    map_a_q;

  logic [NUM_OUTS-1:0]      pwm_in;
  logic [NUM_OUTS-1:0]      pwm_out;
  logic [NUM_OUTS-1:0]      oe_out;
  logic [NUM_OUTS-1:0][1:0] safe_sel;

  assign act_raw = ~(fault_pin_i ^ cfg_fault_high_i);
  assign bypass  = (cfg_filt_per_i == '0);
  assign tick    = ~bypass & (per_cnt_q >= cfg_filt_per_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           per_cnt_q <= '0;
    else if (bypass | tick) per_cnt_q <= '0;
    else                   per_cnt_q <= per_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       map_q <= '1;
    else if (map_wr_i) map_q <= map_wdata_i;
  end

  assign map_a_q = map_q[NF-1:0];

  for (genvar i = 0; i < NF; i++) begin : g_fault
    fg_filter #(.CNT_W(CNT_W)) i_filter (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .act_i        (act_raw[i]),
      .stretch_en_i (cfg_stretch_i),
      .bypass_i     (bypass),
      .tick_i       (tick),
      .cnt_i        (cfg_filt_cnt_i),
      .filt_o       (filt_act[i])
    );

    fg_latch i_latch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .filt_i     (filt_act[i]),
      .clr_mode_i (cfg_clr_mode_i[2*i +: 2]),
      .rec_mode_i (cfg_rec_mode_i[2*i +: 2]),
      .half_i     (half_cyc_i),
      .full_i     (full_cyc_i),
      .clr_i      (flag_clr_i[i]),
      .hold_o     (hold_q[i]),
      .flag_o     (fault_flag_o[i])
    );
  end

  assign fault_now = hold_q | filt_act | (cfg_comb_en_i & act_raw);
  assign irq_o     = fault_flag_o & irq_en_i;

  assign pwm_in   = {pwm_x_i, pwm_b_i, pwm_a_i};
  assign safe_sel = {cfg_safe_x_i, cfg_safe_b_i, cfg_safe_a_i};

  for (genvar c = 0; c < NUM_OUTS; c++) begin : g_out
    fg_gate #(.NF(NF)) i_gate (
      .pwm_i   (pwm_in[c]),
      .fault_i (fault_now),
      .map_i   (map_q[c*NF +: NF]),
      .safe_i  (safe_sel[c]),
      .pwm_o   (pwm_out[c]),
      .oe_o    (oe_out[c])
    );
  end

  assign pwm_a_o = pwm_out[0];
  assign pwm_b_o = pwm_out[1];
  assign pwm_x_o = pwm_out[2];
  assign oe_a_o  = oe_out[0];
  assign oe_b_o  = oe_out[1];
  assign oe_x_o  = oe_out[2];
endmodule

// File: rtl/fault_guard_chk.sv
module fault_guard_chk #(
  parameter int NF = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NF-1:0]   fault_pin_i,
  input logic [NF-1:0]   cfg_fault_high_i,
  input logic [NF-1:0]   cfg_comb_en_i,
  input logic [2*NF-1:0] cfg_clr_mode_i,
  input logic [1:0]      cfg_safe_a_i,
  input logic [NF-1:0]   flag_clr_i,
  input logic            half_cyc_i,
  input logic            full_cyc_i,
  input logic            pwm_a_o,
  input logic            oe_a_o,
  input logic [NF-1:0]   fault_flag_o,
  input logic [NF-1:0]   hold_i,
  input logic [NF-1:0]   filt_i,
  input logic [NF-1:0]   map_a_i
);
  logic [NF-1:0] act;
  assign act = ~(fault_pin_i ^ cfg_fault_high_i);

  assert_tristate_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_a_o |-> !pwm_a_o);

  assert_comb_override_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(act & cfg_comb_en_i & map_a_i)) |-> (oe_a_o == (cfg_safe_a_i < 2'd2)));

  assert_release_on_point_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(hold_i) & ~hold_i)) |-> ($past(half_cyc_i) || $past(full_cyc_i)));

  for (genvar i = 0; i < NF; i++) begin : g_bit
    assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_flag_o[i] && !flag_clr_i[i]) |=> fault_flag_o[i]);

    assert_safety_keeps_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_clr_mode_i[2*i+1] && fault_flag_o[i] && filt_i[i]) |=> fault_flag_o[i]);
  end
endmodule

bind fault_guard fault_guard_chk #(.NF(NF)) i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .fault_pin_i      (fault_pin_i),
  .cfg_fault_high_i (cfg_fault_high_i),
  .cfg_comb_en_i    (cfg_comb_en_i),
  .cfg_clr_mode_i   (cfg_clr_mode_i),
  .cfg_safe_a_i     (cfg_safe_a_i),
  .flag_clr_i       (flag_clr_i),
  .half_cyc_i       (half_cyc_i),
  .full_cyc_i       (full_cyc_i),
  .pwm_a_o          (pwm_a_o),
  .oe_a_o           (oe_a_o),
  .fault_flag_o     (fault_flag_o),
  .hold_i           (hold_q),
  .filt_i           (filt_act),
  .map_a_i          (map_a_q)
);

// File: tb/test_fault_guard.sv
module test_fault_guard;
  localparam int NF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NF-1:0] fault_pin = '0;
  logic half_cyc = 1'b0, full_cyc = 1'b0;
  logic pwm_a = 1'b1, pwm_b = 1'b1, pwm_x = 1'b1;
  logic [NF-1:0] high = '1;
  logic [7:0] per = '0;
  logic [2:0] cnt = '0;
  logic stretch = 1'b0;
  logic [NF-1:0] comb_en = '0;
  logic [2*NF-1:0] clr_mode = '0;
  logic [2*NF-1:0] rec_mode = '1;
  logic [1:0] safe_a = '0, safe_b = '0, safe_x = '0;
  logic map_wr = 1'b0;
  logic [3*NF-1:0] map_wdata = '1;
  logic [NF-1:0] flag_clr = '0;
  logic [NF-1:0] irq_en = '0;
  logic pa_o, pb_o, px_o, oa_o, ob_o, ox_o;
  logic [NF-1:0] flag_o, irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fault_guard i_fault_guard (
    .clk_i(clk), .rst_ni(rst_n), .fault_pin_i(fault_pin),
    .half_cyc_i(half_cyc), .full_cyc_i(full_cyc),
    .pwm_a_i(pwm_a), .pwm_b_i(pwm_b), .pwm_x_i(pwm_x),
    .cfg_fault_high_i(high), .cfg_filt_per_i(per), .cfg_filt_cnt_i(cnt),
    .cfg_stretch_i(stretch), .cfg_comb_en_i(comb_en),
    .cfg_clr_mode_i(clr_mode), .cfg_rec_mode_i(rec_mode),
    .cfg_safe_a_i(safe_a), .cfg_safe_b_i(safe_b), .cfg_safe_x_i(safe_x),
    .map_wr_i(map_wr), .map_wdata_i(map_wdata), .flag_clr_i(flag_clr),
    .irq_en_i(irq_en), .pwm_a_o(pa_o), .pwm_b_o(pb_o), .pwm_x_o(px_o),
    .oe_a_o(oa_o), .oe_b_o(ob_o), .oe_x_o(ox_o),
    .fault_flag_o(flag_o), .irq_o(irq_o)
  );

  // {safe[1:0], map_a bit0, pwm_a, pin0, exp_o, exp_oe}
  localparam logic [6:0] VEC [8] = '{
    7'b00_1_1_1_0_1,
    7'b01_1_0_1_1_1,
    7'b10_1_1_1_0_0,
    7'b11_1_0_1_0_0,
    7'b00_0_1_1_1_1,
    7'b01_0_0_1_0_1,
    7'b10_1_1_0_1_1,
    7'b01_1_0_0_0_1
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_half();
    half_cyc = 1'b1; step(1); half_cyc = 1'b0;
  endtask

  task automatic pulse_full();
    full_cyc = 1'b1; step(1); full_cyc = 1'b0;
  endtask

  task automatic pulse_clr(input logic [NF-1:0] m);
    flag_clr = m; step(1); flag_clr = '0;
  endtask

  task automatic cleanup();
    fault_pin = '0;
    step(12);
    pulse_clr('1);
    pulse_half();
  endtask

  initial begin
    #(20 * 60000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    pwm_b = 1'b0;
    step(1);
    // R1 reset state
    check("R1 a", {pa_o, oa_o}, 2'b11);
    check("R1 b", {pb_o, ob_o}, 2'b01);
    check("R1 x", {px_o, ox_o}, 2'b11);
    check("R1 flags", {irq_o, flag_o}, 8'h00);
    pwm_b = 1'b1;

    // R3 reset map, R5 bypass latency
    fault_pin[3] = 1'b1;
    #2;
    check("R5 no change before edge", pa_o, 1'b1);
    step(1);
    check("R3 reset map all outputs", {pa_o, pb_o, px_o}, 3'b000);
    step(1);
    check("R9 flag set", flag_o, 4'h8);
    check("R9 irq masked", irq_o, 4'h0);
    irq_en = 4'h8;
    #1;
    check("R9 irq enabled", irq_o, 4'h8);
    irq_en = '0;
    fault_pin[3] = 1'b0;
    step(3);
    check("R10 held until point", pa_o, 1'b0);
    pulse_half();
    check("R10 auto release", {pa_o, pb_o, px_o}, 3'b111);
    check("R9 flag sticky", flag_o, 4'h8);
    pulse_clr(4'h8);
    check("R9 flag cleared", flag_o, 4'h0);

    // R3 R4 R8 table through the unfiltered path
    comb_en = 4'b0001;
    for (int k = 0; k < 8; k++) begin
      safe_a = VEC[k][6:5];
      map_wdata = {8'hFF, 3'b111, VEC[k][4]};
      map_wr = 1'b1;
      pwm_a = VEC[k][3];
      step(1);
      map_wr = 1'b0;
      fault_pin[0] = VEC[k][2];
      #2;
      check($sformatf("R4 R8 R3 vec%0d", k), {pa_o, oa_o}, VEC[k][1:0]);
      fault_pin[0] = 1'b0;
      step(1);
    end
    check("R8 no latch from comb-only pulse", flag_o, 4'h0);
    comb_en = '0;
    safe_a = '0;
    pwm_a = 1'b1;
    map_wdata = '1;
    map_wr = 1'b1;
    step(1);
    map_wr = 1'b0;

    // R3 map selects outputs: fault0 drives A only
    map_wdata = {4'h0, 4'h0, 4'h1};
    map_wr = 1'b1;
    step(1);
    map_wr = 1'b0;
    fault_pin[0] = 1'b1;
    step(2);
    check("R3 A only", {pa_o, pb_o, px_o}, 3'b011);
    cleanup();
    map_wdata = '1;
    map_wr = 1'b1;
    step(1);
    map_wr = 1'b0;

    // R2 polarity
    high[2] = 1'b0;
    fault_pin[2] = 1'b1;
    step(3);
    check("R2 high pin inactive when low-active", flag_o, 4'h0);
    fault_pin[2] = 1'b0;
    step(3);
    check("R2 low pin faults when low-active", flag_o, 4'h4);
    high[2] = 1'b1;
    cleanup();
    check("R2 restored", {pa_o, flag_o}, 5'h10);

    // R13 recovery timing on fault1
    rec_mode = 8'b11_11_10_11;
    fault_pin[1] = 1'b1;
    step(2);
    fault_pin[1] = 1'b0;
    step(2);
    pulse_half();
    check("R13 full-only ignores half", pa_o, 1'b0);
    pulse_full();
    check("R13 full releases", pa_o, 1'b1);
    rec_mode = 8'b11_11_00_11;
    fault_pin[1] = 1'b1;
    step(2);
    fault_pin[1] = 1'b0;
    step(2);
    pulse_half();
    pulse_full();
    check("R13 none never releases", pa_o, 1'b0);
    rec_mode = '1;
    pulse_half();
    check("R13 both releases on half", pa_o, 1'b1);
    cleanup();

    // R12 manual with safety on fault0
    clr_mode = 8'b00_00_00_10;
    fault_pin[0] = 1'b1;
    step(3);
    check("R12 flag set", flag_o, 4'h1);
    pulse_clr(4'h1);
    check("R12 clear ignored while active", flag_o, 4'h1);
    fault_pin[0] = 1'b0;
    step(2);
    pulse_half();
    check("R12 held with flag set", pa_o, 1'b0);
    pulse_clr(4'h1);
    check("R12 clear accepted after fault", flag_o, 4'h0);
    pulse_half();
    check("R12 release", pa_o, 1'b1);
    cleanup();

    // R11 manual without safety on fault0
    clr_mode = 8'b00_00_00_01;
    fault_pin[0] = 1'b1;
    step(3);
    pulse_clr(4'h1);
    step(2);
    check("R11 clear accepted while active", flag_o, 4'h0);
    check("R11 still overridden", pa_o, 1'b0);
    fault_pin[0] = 1'b0;
    step(2);
    pulse_half();
    check("R11 release without new clear", pa_o, 1'b1);
    clr_mode = '0;
    cleanup();

    // R6 sampled filter P=2 C=1
    per = 8'd2;
    cnt = 3'd1;
    step(2);
    fault_pin[0] = 1'b1;
    step(1);
    fault_pin[0] = 1'b0;
    step(10);
    check("R6 glitch rejected", flag_o, 4'h0);
    fault_pin[0] = 1'b1;
    step(10);
    check("R6 long pulse accepted", flag_o, 4'h1);
    cleanup();

    // R7 stretch with P=1 C=1
    per = 8'd1;
    step(2);
    fault_pin[0] = 1'b1;
    step(1);
    fault_pin[0] = 1'b0;
    step(6);
    check("R7 glitch rejected without stretch", flag_o, 4'h0);
    stretch = 1'b1;
    step(1);
    fault_pin[0] = 1'b1;
    step(1);
    fault_pin[0] = 1'b0;
    step(6);
    check("R7 stretched glitch accepted", flag_o, 4'h1);
    stretch = 1'b0;
    cleanup();
    per = '0;
    cnt = '0;
    step(2);
    check("R1 outputs back to pass-through", {pa_o, pb_o, px_o, flag_o}, 7'b1110000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule